// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a shift register with the directions of recently resolved branches. It also keeps a table of two-bit saturating counters. In the default mode the table index is the history XORed with the word-aligned bits of the branch address, so one branch can use different counters depending on the path that led to it. A parameter can instead select plain history indexing, where the address plays no part.

The fetch side presents a branch address and gets a taken/not-taken guess in the same cycle, together with the history value that produced it. Once the branch resolves, the execute side returns the address, that history snapshot and the real outcome. The block then trains the counter that made the guess and shifts the outcome into the history.

Top module: `gshare_predictor`

## Requirements
- R1: The history register has HIST_W bits, where 1 means taken. Each accepted update shifts it left and puts the outcome into bit 0. Without an update the register does not change. `pred_hist` shows its current value.
- R2: A synchronous active-high reset clears the history to zero and sets every counter to weakly taken, so every address predicts taken after reset.
- R3: `pred_taken` is the top bit of the counter selected for `pred_pc` and the current history. It is valid in the same cycle, with no clock edge in between.
- R4: With HASH_MODE=1, the index is history XOR `pc[PC_LSB +: HIST_W]`. Address bits below PC_LSB and above the indexed slice have no effect.
- R5: With HASH_MODE=0, the index is the history alone, and the address has no effect.
- R6: An update trains the counter indexed by `upd_hist` and `upd_pc`, not by the current history. It adds one on taken and subtracts one on not taken.
- R7: Counters saturate. Taken at 3 stays at 3, and not taken at 0 stays at 0.
- R8: Counter encoding: 0 is strongly not taken, 1 is weakly not taken, 2 is weakly taken, 3 is strongly taken. From a strong state, two contrary outcomes in a row are needed to flip the prediction.
- R9: When a prediction and an update hit the same counter in the same cycle, the prediction reflects the value before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_pc | input | PC_W | Address of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, 1 means taken |
| pred_hist | output | HIST_W | History value used for this prediction |
| upd_valid | input | 1 | Resolved outcome present this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_hist | input | HIST_W | History snapshot taken at prediction time |
| upd_taken | input | 1 | Resolved direction |

## Verification
The hardest case to reach from the ports is a chosen counter driven through every state while the history keeps moving. Each update shifts the history, so a plain repeated branch lands on a new counter every time. The stimulus therefore passes a fixed snapshot on `upd_hist`, which pins training to one index. It then reads that counter back by picking a `pred_pc` whose address bits, XORed with the present history, give the same index. The same method sets up a prediction and an update on one counter in the same cycle. Two instances, one per indexing mode, follow a vector walk that is checked against a model kept in the bench.

// File: rtl/gshare_pkg.sv
package gshare_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_STRONG_NT = 2'd0;
  localparam ctr_t CTR_WEAK_NT   = 2'd1;
  localparam ctr_t CTR_WEAK_T    = 2'd2;
  localparam ctr_t CTR_STRONG_T  = 2'd3;

  // saturating step of a direction counter
  function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
    ctr_t r;
    if (taken) r = (c == CTR_STRONG_T)  ? c : c + 2'd1;
    else       r = (c == CTR_STRONG_NT) ? c : c - 2'd1;
    return r;
  endfunction

endpackage

// File: rtl/gshare_history.sv
module gshare_history #(
  parameter int HIST_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              shift_bit,
  output logic [HIST_W-1:0] hist
);

  always_ff @(posedge clk) begin
    if (rst)           hist <= '0;
    else if (shift_en) hist <= {hist[HIST_W-2:0], shift_bit};
  end

  AST_HIST_SHIFT_IN: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> hist[0] == $past(shift_bit)); // R1
  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(hist)); // R1
  AST_HIST_RST: assert property (@(posedge clk)
    rst |=> hist == '0); // R2

endmodule

// File: rtl/gshare_hash.sv
module gshare_hash #(
  parameter int HIST_W    = 6,
  parameter int PC_W      = 32,
  parameter int PC_LSB    = 2,
  parameter bit HASH_MODE = 1'b1
) (
  input  logic [HIST_W-1:0] hist,
  input  logic [PC_W-1:0]   pc,
  output logic [HIST_W-1:0] idx
);

  logic unused_pc_fold;
  assign unused_pc_fold = ^pc;

  generate
    if (HASH_MODE) begin : g_xor
      assign idx = hist ^ pc[PC_LSB +: HIST_W];
    end else begin : g_plain
      assign idx = hist;
    end
  endgenerate

endmodule

// File: rtl/gshare_pht.sv
module gshare_pht
  import gshare_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);

  localparam int DEPTH = 1 << IDX_W;

  ctr_t mem [DEPTH];
  ctr_t wr_cur;

  assign rd_ctr = mem[rd_idx];
  assign wr_cur = mem[wr_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_WEAK_T;
    end else if (wr_en) begin
      mem[wr_idx] <= ctr_step(wr_cur, wr_taken);
    end
  end

  AST_CTR_INC: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_taken && wr_cur != CTR_STRONG_T) |=>
      mem[$past(wr_idx)] == ctr_t'($past(wr_cur) + 2'd1)); // R6
  AST_CTR_DEC: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_taken && wr_cur != CTR_STRONG_NT) |=>
      mem[$past(wr_idx)] == ctr_t'($past(wr_cur) - 2'd1)); // R6
  AST_SAT_HI: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_taken && wr_cur == CTR_STRONG_T) |=>
      mem[$past(wr_idx)] == CTR_STRONG_T); // R7
  AST_SAT_LO: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_taken && wr_cur == CTR_STRONG_NT) |=>
      mem[$past(wr_idx)] == CTR_STRONG_NT); // R7

endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor
  import gshare_pkg::*;
#(
  parameter int HIST_W    = 6,
  parameter int PC_W      = 32,
  parameter int PC_LSB    = 2,
  parameter bit HASH_MODE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PC_W-1:0]   pred_pc,
  output logic              pred_taken,
  output logic [HIST_W-1:0] pred_hist,
  input  logic              upd_valid,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic [HIST_W-1:0] upd_hist,
  input  logic              upd_taken
);

  localparam int IDX_W = HIST_W;

  logic [HIST_W-1:0] hist_q;
  logic [IDX_W-1:0]  rd_idx;
  logic [IDX_W-1:0]  wr_idx;
  ctr_t              rd_ctr;

  gshare_history #(.HIST_W(HIST_W)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .shift_en (upd_valid),
    .shift_bit(upd_taken),
    .hist     (hist_q)
  );

  gshare_hash #(.HIST_W(HIST_W), .PC_W(PC_W), .PC_LSB(PC_LSB), .HASH_MODE(HASH_MODE)) u_rd_hash (
    .hist(hist_q),
    .pc  (pred_pc),
    .idx (rd_idx)
  );

  gshare_hash #(.HIST_W(HIST_W), .PC_W(PC_W), .PC_LSB(PC_LSB), .HASH_MODE(HASH_MODE)) u_wr_hash (
    .hist(upd_hist),
    .pc  (upd_pc),
    .idx (wr_idx)
  );

  gshare_pht #(.IDX_W(IDX_W)) u_pht (
    .clk     (clk),
    .rst     (rst),
    .rd_idx  (rd_idx),
    .rd_ctr  (rd_ctr),
    .wr_en   (upd_valid),
    .wr_idx  (wr_idx),
    .wr_taken(upd_taken)
  );

  assign pred_taken = rd_ctr[1];
  assign pred_hist  = hist_q;

  AST_RST_PRED_T: assert property (@(posedge clk)
    rst |=> pred_taken); // R2
  AST_HIST_OUT_SHIFT: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> pred_hist[HIST_W-1:1] == $past(pred_hist[HIST_W-2:0])); // R1

endmodule

// File: tb/gshare_predictor_tb.sv
module gshare_predictor_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HW  = 6;
  localparam int PW  = 32;
  localparam int LSB = 2;
  localparam int NV  = 24;

  // {taken, pc}
  localparam logic [32:0] VEC [NV] = '{
    {1'b1, 32'h0000_0040}, {1'b1, 32'h0000_0040}, {1'b1, 32'h0000_0040}, {1'b0, 32'h0000_0040},
    {1'b1, 32'h0000_0080}, {1'b0, 32'h0000_0080}, {1'b1, 32'h0000_0080}, {1'b0, 32'h0000_0080},
    {1'b0, 32'h0000_1F0C}, {1'b0, 32'h0000_1F0C}, {1'b0, 32'h0000_1F0C}, {1'b1, 32'h0000_1F0C},
    {1'b1, 32'h0000_0040}, {1'b1, 32'h0000_0040}, {1'b1, 32'h0000_0040}, {1'b0, 32'h0000_0040},
    {1'b1, 32'hFFFF_FFFC}, {1'b1, 32'h0000_0104}, {1'b0, 32'h0000_0208}, {1'b1, 32'h0000_0310},
    {1'b0, 32'h0000_0040}, {1'b0, 32'h0000_0040}, {1'b1, 32'h0000_00A8}, {1'b1, 32'h0000_00A8}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [PW-1:0] pred_pc = '0;
  logic          upd_valid = 1'b0;
  logic [PW-1:0] upd_pc = '0;
  logic [HW-1:0] upd_hist = '0;
  logic          upd_taken = 1'b0;
  logic          x_taken, g_taken;
  logic [HW-1:0] x_hist, g_hist;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [1:0]    mx [64];
  logic [1:0]    mg [64];
  logic [HW-1:0] mh;

  always #(CLK_PERIOD/2) clk = ~clk;

  gshare_predictor #(.HIST_W(HW), .PC_W(PW), .PC_LSB(LSB), .HASH_MODE(1'b1)) dut_i (
    .clk(clk), .rst(rst), .pred_pc(pred_pc), .pred_taken(x_taken), .pred_hist(x_hist),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_hist(upd_hist), .upd_taken(upd_taken));

  gshare_predictor #(.HIST_W(HW), .PC_W(PW), .PC_LSB(LSB), .HASH_MODE(1'b0)) dut_g (
    .clk(clk), .rst(rst), .pred_pc(pred_pc), .pred_taken(g_taken), .pred_hist(g_hist),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_hist(upd_hist), .upd_taken(upd_taken));

  function automatic logic [HW-1:0] xidx(input logic [HW-1:0] h, input logic [PW-1:0] pc);
    return h ^ pc[7:2];
  endfunction

  function automatic logic [1:0] bump(input logic [1:0] c, input logic t);
    if (t) return (c == 2'd3) ? 2'd3 : c + 2'd1;
    return (c == 2'd0) ? 2'd0 : c - 2'd1;
  endfunction

  task automatic chk(input logic got, input logic exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  task automatic chk_h(input logic [HW-1:0] got, input logic [HW-1:0] exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic model_update(input logic [PW-1:0] pc, input logic [HW-1:0] h, input logic t);
    mx[xidx(h, pc)] = bump(mx[xidx(h, pc)], t);
    mg[h] = bump(mg[h], t);
    mh = {mh[HW-2:0], t};
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    upd_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 64; i++) begin
      mx[i] = 2'd2;
      mg[i] = 2'd2;
    end
    mh = '0;
  endtask

  // compare both instances against the model for one address
  task automatic probe(input logic [PW-1:0] pc, input string req);
    @(negedge clk);
    pred_pc = pc;
    #1;
    chk(x_taken, mx[xidx(mh, pc)][1], {req, " R3 R4 xor-mode"});
    chk(g_taken, mg[mh][1], {req, " R3 R5 plain-mode"});
    chk_h(x_hist, mh, {req, " R1 history"});
  endtask

  task automatic apply_update(input logic [PW-1:0] pc, input logic [HW-1:0] h, input logic t);
    @(negedge clk);
    upd_valid = 1'b1;
    upd_pc = pc;
    upd_hist = h;
    upd_taken = t;
    @(posedge clk);
    #1;
    model_update(pc, h, t);
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  // read the xor-mode counter at index tgt through a chosen address
  task automatic probe_idx(input logic [HW-1:0] tgt, input logic [1:0] low, input logic exp, input string req);
    @(negedge clk);
    pred_pc = {24'hABCDEF, mh ^ tgt, low};
    #1;
    chk(x_taken, exp, req);
  endtask

  localparam logic [HW-1:0] TGT = 6'h15;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R2: reset state
    @(negedge clk);
    #1;
    chk_h(x_hist, '0, "R2 history cleared");
    foreach (VEC[k]) begin
      if (k < 3) begin
        pred_pc = VEC[k*5][31:0];
        #1;
        chk(x_taken, 1'b1, "R2 weakly taken after reset");
        chk(g_taken, 1'b1, "R2 weakly taken after reset plain");
      end
    end

    // vector walk: predict, then train with the snapshot from that prediction
    for (int k = 0; k < NV; k++) begin
      probe(VEC[k][31:0], "walk");
      apply_update(VEC[k][31:0], mh, VEC[k][32]);
    end
    // address bits outside the slice must not matter
    probe(32'h0000_0043, "R4 low bits");
    probe(32'h7700_0040, "R4 high bits");

    // R6 R7 R8: pin one counter via a fixed snapshot while history moves on
    for (int i = 0; i < 4; i++) apply_update(32'h0, TGT, 1'b0);
    probe_idx(TGT, 2'b00, 1'b0, "R7 saturated low");
    apply_update(32'h0, TGT, 1'b0);
    apply_update(32'h0, TGT, 1'b1);
    probe_idx(TGT, 2'b11, 1'b0, "R8 one taken from strong NT keeps NT");
    apply_update(32'h0, TGT, 1'b1);
    probe_idx(TGT, 2'b01, 1'b1, "R8 second taken flips to T");
    for (int i = 0; i < 3; i++) apply_update(32'h0, TGT, 1'b1);
    apply_update(32'h0, TGT, 1'b0);
    probe_idx(TGT, 2'b00, 1'b1, "R7 saturated high then one NT stays T");
    probe(32'h0000_0040, "R6 model after pinned training");

    // R9: predict and update the same counter in one cycle (counter now 2)
    @(negedge clk);
    pred_pc = {24'h0, mh ^ TGT, 2'b00};
    upd_valid = 1'b1;
    upd_pc = 32'h0;
    upd_hist = TGT;
    upd_taken = 1'b0;
    #1;
    chk(x_taken, 1'b1, "R9 pre-update value seen");
    @(posedge clk);
    #1;
    model_update(32'h0, TGT, 1'b0);
    @(negedge clk);
    upd_valid = 1'b0;
    probe_idx(TGT, 2'b00, 1'b0, "R9 update lands after the cycle");

    // R1: no update leaves the history alone
    probe(32'h0000_0100, "R1 hold a");
    probe(32'h0000_0100, "R1 hold b");

    // R2: reset again clears trained state
    do_reset();
    probe_idx(TGT, 2'b00, 1'b1, "R2 counters back to weakly taken");
    probe(32'h0000_0080, "R2 after second reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule